// File: doc/BRIEF.md
# Bit-Clear Execute Unit with Immediate Shifter

This unit carries out the 32-bit wide register form of the bit-clear operation in an execute pipeline. It takes a 32-bit instruction word, the two source operand values already read from the register file, and the current condition flags. It returns the destination register index, the result, a write-enable and the new flags. The unit also offers the two source register indices, decoded straight from the word, so that the register file can be read.

The second operand first goes through an immediate shift stage. That stage handles logical left, logical right, arithmetic right, rotate right, and rotate-with-extend through carry, and it produces a carry-out. The result is the first operand ANDed with the complement of the shifted second operand. When the set-flags bit is on, N, Z and C take their new values. V is never touched.

The decode, the shift and the logic are combinational. The outputs are registered, so each result appears one clock after its instruction was presented. A word that is not this encoding marks its outcome as invalid. Such a word writes no register and leaves the flags unchanged.

Top module: `bicx_exec`

## Requirements
- R1: One cycle after an instruction is presented, `result_o` equals `opa_i & ~S`. S is `opb_i` after the shift. `rd_o` equals instruction bits [11:8].
- R2: A word is valid only when bits [31:25]=1110101, bits [24:21]=0001 and bit 15 is 0. For any other word, `valid_o` and `wr_o` are 0 one cycle later and `flags_o` equals the presented `flags_i`. For a valid word, `valid_o` and `wr_o` are 1.
- R3: Flags are packed as {N,Z,C,V} in bits [3:0]. When bit 20 is 1, N equals result bit 31. Z is 1 exactly when the result is all zeros.
- R4: When bit 20 is 1, C takes the carry-out of the shift stage.
- R5: V in `flags_o` always equals the V bit of the presented `flags_i`.
- R6: When bit 20 is 0, `flags_o` equals the presented `flags_i`.
- R7: The shift amount is {bits[14:12], bits[7:6]}. The shift type in bits [5:4] is 00 for logical left, 01 for logical right, 10 for arithmetic right and 11 for rotate right. For a logical left shift, the carry-out is the last bit shifted out. A logical left shift of 0 passes the operand unchanged, and its carry-out is the incoming C.
- R8: For a logical or arithmetic right shift, an encoded amount of 0 means a shift of 32. The carry-out is the last bit shifted out, which is bit 31 of the operand for a shift of 32.
- R9: A rotate right by 1 to 31 has a carry-out equal to the new bit 31.
- R10: Type 11 with amount 0 selects rotate-with-extend. This shifts right by one, moves the incoming C into bit 31, and gives the old bit 0 as the carry-out.
- R11: `rn_sel_o` and `rm_sel_o` are combinational copies of bits [19:16] and [3:0]. While reset is active, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| opa_i | input | XLEN | First source value |
| opb_i | input | XLEN | Second source value, before the shift |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| rn_sel_o | output | 4 | First source register index |
| rm_sel_o | output | 4 | Second source register index |
| rd_o | output | 4 | Destination register index |
| result_o | output | XLEN | Bit-clear result |
| wr_o | output | 1 | Register write enable |
| flags_o | output | 4 | Updated flags {N,Z,C,V} |
| valid_o | output | 1 | Instruction matched this encoding |

## Verification
The cases that are hardest to reach all hinge on an encoded amount of zero. The same zero amount means no shift for a logical left shift, a shift of 32 for the right shifts, and rotate-with-extend for type 11. The carry in each of these cases comes from a different place: the incoming flag, bit 31, or bit 0.

The stimulus sweeps every shift type at amounts 0, 1 and 31 and at two further amounts. It does this with the set-flags bit both on and off, under operand patterns chosen so that each carry source differs from the others. It also flips the incoming C between vectors. Corrupted opcode bits and a set bit 15 then confirm that invalid words leave the flags alone.

// File: rtl/bicx_pkg.sv
package bicx_pkg;

    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shkind_e;

    typedef struct packed {
        logic       ok;
        logic       setf;
        logic [3:0] rd;
        shkind_e    kind;
        logic [4:0] amt;
        logic       rrx;
    } bicx_dec_t;

endpackage

// File: rtl/bicx_decode.sv
module bicx_decode
    import bicx_pkg::*;
(
    input  logic [31:0] instr,
    output bicx_dec_t   dec,
    output logic [3:0]  rn_sel,
    output logic [3:0]  rm_sel
);

    localparam logic [6:0] OP_HI = 7'b1110101;
    localparam logic [3:0] OP_LO = 4'b0001;

    always_comb begin
        dec.ok   = (instr[31:25] == OP_HI) && (instr[24:21] == OP_LO) && !instr[15];
        dec.setf = instr[20];
        dec.rd   = instr[11:8];
        dec.kind = shkind_e'(instr[5:4]);
        dec.amt  = {instr[14:12], instr[7:6]};
        dec.rrx  = (instr[5:4] == 2'b11) && ({instr[14:12], instr[7:6]} == 5'd0);
        rn_sel   = instr[19:16];
        rm_sel   = instr[3:0];
    end

endmodule

// File: rtl/bicx_shifter.sv
module bicx_shifter
    import bicx_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic [XLEN-1:0] x,
    input  shkind_e         kind,
    input  logic [AW-1:0]   amt,
    input  logic            rrx,
    input  logic            c_in,
    output logic [XLEN-1:0] y,
    output logic            c_out
);

    localparam int EW = XLEN + 1;

    logic [EW-1:0]   ext_l;
    logic [EW-1:0]   ext_r;
    logic [EW-1:0]   ext_a;
    logic [XLEN-1:0] rot;

    always_comb begin
        ext_l = {1'b0, x} << amt;
        ext_r = {x, 1'b0} >> amt;
        ext_a = EW'($signed({x, 1'b0}) >>> amt);
        rot   = (x >> amt) | (x << (AW+1)'(XLEN - int'(amt)));
    end

    always_comb begin
        y     = x;
        c_out = c_in;
        unique case (kind)
            SH_LSL: begin
                if (amt != '0) begin
                    y     = ext_l[XLEN-1:0];
                    c_out = ext_l[XLEN];
                end
            end
            SH_LSR: begin
                if (amt == '0) begin
                    y     = '0;
                    c_out = x[XLEN-1];
                end else begin
                    y     = ext_r[XLEN:1];
                    c_out = ext_r[0];
                end
            end
            SH_ASR: begin
                if (amt == '0) begin
                    y     = {XLEN{x[XLEN-1]}};
                    c_out = x[XLEN-1];
                end else begin
                    y     = ext_a[XLEN:1];
                    c_out = ext_a[0];
                end
            end
            SH_ROR: begin
                if (rrx) begin
                    y     = {c_in, x[XLEN-1:1]};
                    c_out = x[0];
                end else begin
                    y     = rot;
                    c_out = rot[XLEN-1];
                end
            end
            default: begin
                y     = x;
                c_out = c_in;
            end
        endcase
    end

endmodule

// File: rtl/bicx_alu.sv
module bicx_alu
    import bicx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b_sh,
    input  logic            sh_c,
    input  logic            ok,
    input  logic            setf,
    input  logic [3:0]      flags_in,
    output logic [XLEN-1:0] res,
    output logic [3:0]      flags_nxt,
    output logic            wr
);

    always_comb begin
        res       = a & ~b_sh;
        wr        = ok;
        flags_nxt = flags_in;
        if (ok && setf) begin
            flags_nxt[FLG_N] = res[XLEN-1];
            flags_nxt[FLG_Z] = (res == '0);
            flags_nxt[FLG_C] = sh_c;
        end
    end

endmodule

// File: rtl/bicx_exec.sv
module bicx_exec
    import bicx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic [3:0]      flags_i,
    output logic [3:0]      rn_sel_o,
    output logic [3:0]      rm_sel_o,
    output logic [3:0]      rd_o,
    output logic [XLEN-1:0] result_o,
    output logic            wr_o,
    output logic [3:0]      flags_o,
    output logic            valid_o
);

    localparam int AW = 5;

    bicx_dec_t       dec;
    logic [XLEN-1:0] b_sh;
    logic            sh_c;
    logic [XLEN-1:0] res;
    logic [3:0]      flags_nxt;
    logic            wr;

    bicx_decode u_dec (
        .instr  (instr_i),
        .dec    (dec),
        .rn_sel (rn_sel_o),
        .rm_sel (rm_sel_o)
    );

    bicx_shifter #(.XLEN(XLEN), .AW(AW)) u_sh (
        .x     (opb_i),
        .kind  (dec.kind),
        .amt   (dec.amt),
        .rrx   (dec.rrx),
        .c_in  (flags_i[FLG_C]),
        .y     (b_sh),
        .c_out (sh_c)
    );

    bicx_alu #(.XLEN(XLEN)) u_alu (
        .a         (opa_i),
        .b_sh      (b_sh),
        .sh_c      (sh_c),
        .ok        (dec.ok),
        .setf      (dec.setf),
        .flags_in  (flags_i),
        .res       (res),
        .flags_nxt (flags_nxt),
        .wr        (wr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_o     <= '0;
            result_o <= '0;
            wr_o     <= 1'b0;
            flags_o  <= '0;
            valid_o  <= 1'b0;
        end else begin
            rd_o     <= dec.rd;
            result_o <= res;
            wr_o     <= wr;
            flags_o  <= flags_nxt;
            valid_o  <= dec.ok;
        end
    end

    // R1: the result never has a bit set where the first operand was clear
    assert_clear_subset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dec.ok |=> ((result_o & ~$past(opa_i)) == '0));

    // R2: a word that fails decode neither writes nor alters the flags
    assert_invalid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.ok |=> (!wr_o && !valid_o && flags_o == $past(flags_i)));

    // R3: N and Z follow the registered result when flags are set
    assert_nz_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.ok && dec.setf) |=> (flags_o[FLG_N] == result_o[XLEN-1]
                                  && flags_o[FLG_Z] == (result_o == '0)));

    // R5: V passes through in every case
    assert_v_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (flags_o[FLG_V] == $past(flags_i[FLG_V])));

    // R6: without the set-flags bit every flag is carried over
    assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.setf |=> (flags_o == $past(flags_i)));

    // R7: a left shift of zero keeps the operand and the incoming carry
    assert_lsl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.ok && dec.setf && dec.kind == SH_LSL && dec.amt == '0)
        |=> (result_o == ($past(opa_i) & ~$past(opb_i))
             && flags_o[FLG_C] == $past(flags_i[FLG_C])));

    // R10: rotate-with-extend carries out the old bit 0
    assert_rrx_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.ok && dec.setf && dec.rrx) |=> (flags_o[FLG_C] == $past(opb_i[0])));

endmodule

// File: tb/bicx_exec_tb.sv
module bicx_exec_tb;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     instr_i = '0;
    logic [XLEN-1:0] opa_i = '0;
    logic [XLEN-1:0] opb_i = '0;
    logic [3:0]      flags_i = '0;
    logic [3:0]      rn_sel_o, rm_sel_o, rd_o, flags_o;
    logic [XLEN-1:0] result_o;
    logic            wr_o, valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bicx_exec #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .opa_i(opa_i), .opb_i(opb_i),
        .flags_i(flags_i), .rn_sel_o(rn_sel_o), .rm_sel_o(rm_sel_o), .rd_o(rd_o),
        .result_o(result_o), .wr_o(wr_o), .flags_o(flags_o), .valid_o(valid_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Single-bit stepping model of the shift stage
    task automatic ref_shift(input logic [31:0] x, input logic [1:0] st, input logic [4:0] a,
                             input logic cin, output logic [31:0] o, output logic co);
        int n;
        o  = x;
        co = cin;
        if (st == 2'b11 && a == 5'd0) begin
            co = x[0];
            o  = {cin, x[31:1]};
            return;
        end
        n = int'(a);
        if (n == 0 && (st == 2'b01 || st == 2'b10)) n = 32;
        for (int i = 0; i < n; i++) begin
            case (st)
                2'b00: begin co = o[31]; o = {o[30:0], 1'b0}; end
                2'b01: begin co = o[0];  o = {1'b0, o[31:1]}; end
                2'b10: begin co = o[0];  o = {o[31], o[31:1]}; end
                default: begin co = o[0]; o = {o[0], o[31:1]}; end
            endcase
        end
    endtask

    function automatic logic [31:0] mk(input logic s, input logic [3:0] rn, input logic [4:0] amt,
                                       input logic [3:0] rd, input logic [1:0] st,
                                       input logic [3:0] rm);
        return {7'b1110101, 4'b0001, s, rn, 1'b0, amt[4:2], rd, amt[1:0], st, rm};
    endfunction

    task automatic run_vec(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                           input logic [3:0] fl);
        logic [31:0] sh, er;
        logic        co;
        logic [3:0]  ef;
        logic        ok;
        @(negedge clk);
        instr_i = ins; opa_i = a; opb_i = b; flags_i = fl;
        #1;
        chk("R11", "rn_sel", {28'd0, rn_sel_o}, {28'd0, ins[19:16]});
        chk("R11", "rm_sel", {28'd0, rm_sel_o}, {28'd0, ins[3:0]});
        ref_shift(b, ins[5:4], {ins[14:12], ins[7:6]}, fl[1], sh, co);
        er = a & ~sh;
        ok = (ins[31:25] == 7'b1110101) && (ins[24:21] == 4'b0001) && !ins[15];
        ef = fl;
        if (ok && ins[20]) ef = {er[31], (er == 0), co, fl[0]};
        @(negedge clk);
        chk("R2", "valid", {31'd0, valid_o}, {31'd0, ok});
        chk("R2", "wr", {31'd0, wr_o}, {31'd0, ok});
        chk("R5", "flag V", {31'd0, flags_o[0]}, {31'd0, fl[0]});
        if (ok) begin
            chk("R1", "result", result_o, er);
            chk("R1", "rd", {28'd0, rd_o}, {28'd0, ins[11:8]});
            if (ins[20]) begin
                chk("R3", "flags N/Z", {30'd0, flags_o[3:2]}, {30'd0, ef[3:2]});
                case (ins[5:4])
                    2'b00:   chk("R7",  "LSL carry", {31'd0, flags_o[1]}, {31'd0, ef[1]});
                    2'b11:   if ({ins[14:12], ins[7:6]} == 5'd0)
                                 chk("R10", "RRX carry", {31'd0, flags_o[1]}, {31'd0, ef[1]});
                             else
                                 chk("R9", "ROR carry", {31'd0, flags_o[1]}, {31'd0, ef[1]});
                    default: chk("R8", "right carry", {31'd0, flags_o[1]}, {31'd0, ef[1]});
                endcase
                chk("R4", "flag C", {31'd0, flags_o[1]}, {31'd0, ef[1]});
            end else begin
                chk("R6", "flags held", {28'd0, flags_o}, {28'd0, fl});
            end
        end else begin
            chk("R2", "flags held on invalid", {28'd0, flags_o}, {28'd0, fl});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        logic [4:0]  amts [5];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hFFFF_FFFF;
        pats[3] = 32'h1234_5678;

        repeat (3) @(negedge clk);
        chk("R11", "reset result", result_o, 32'd0);
        chk("R11", "reset wr", {31'd0, wr_o}, 32'd0);
        chk("R11", "reset flags", {28'd0, flags_o}, 32'd0);
        chk("R11", "reset valid", {31'd0, valid_o}, 32'd0);
        rst_n = 1'b1;

        for (int st = 0; st < 4; st++) begin
            for (int s = 0; s < 2; s++) begin
                amts[0] = 5'd0; amts[1] = 5'd1; amts[2] = 5'd31;
                amts[3] = 5'($urandom_range(2, 30)); amts[4] = 5'($urandom_range(2, 30));
                for (int ai = 0; ai < 5; ai++) begin
                    for (int p = 0; p < 4; p++) begin
                        logic [31:0] a;
                        logic [3:0]  fl;
                        a  = (p == 3) ? $urandom : ~pats[(p + 1) % 4];
                        fl = 4'((st * 5 + ai + p) & 15);
                        run_vec(mk(s[0], 4'(p + 1), amts[ai], 4'(ai + 3), st[1:0], 4'(p + 7)),
                                a, pats[p], fl);
                        run_vec(mk(s[0], 4'(p), amts[ai], 4'(ai), st[1:0], 4'(p)),
                                $urandom, $urandom, fl ^ 4'b0010);
                    end
                end
            end
        end

        // all-zero result with flags set, and invalid encodings
        run_vec(mk(1'b1, 4'd2, 5'd0, 4'd5, 2'b00, 4'd3), 32'h0F0F_0F0F, 32'hFFFF_FFFF, 4'b0001);
        run_vec(mk(1'b1, 4'd2, 5'd4, 4'd5, 2'b01, 4'd3) | 32'h0000_8000, 32'hFFFF_FFFF, 32'd0, 4'b1011);
        run_vec(mk(1'b1, 4'd2, 5'd4, 4'd5, 2'b01, 4'd3) ^ 32'h0040_0000, 32'hFFFF_FFFF, 32'd0, 4'b0100);
        run_vec(mk(1'b1, 4'd2, 5'd4, 4'd5, 2'b10, 4'd3) ^ 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 4'b1111);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule